// File: doc/BRIEF.md
# TDM Frame Sync Pulse Generator

This block produces eight frame-sync strobes for a time-division multiplexed PCM bus. Four strobes belong to the transmit side and four to the receive side. Two slot counters advance on the falling edge of the bit clock. Each counter is aligned to its own frame-start input, and a slot always spans eight bit clocks. Each strobe holds a six-bit slot assignment. The strobe is high for the whole slot in which its reference counter equals that assignment. An assignment whose top bit is set disables the strobe.

A static mode strap selects how the receive strobes are timed. In separate mode they follow the receive frame start. In shared mode all eight strobes follow the transmit frame start. A shared active-low bus enable is driven low while any strobe it covers is high. It stands in for an open-drain pull-low that drives the tri-state enable of a backplane line driver.

New assignments come in through a one-cycle write strobe. Each one is parked in a pending register. It is copied into the active register only at the start of the next slot on that strobe's timing reference, so a pulse is never truncated and never begins partway through a slot.

Each slot counter is a three-state machine:
- IDLE: the reset state, with no frame seen. A frame-start rise moves it to RUN.
- RUN: counting. A frame-start rise restarts the count (RUN to RUN). The end of slot 63 moves it to HOLD.
- HOLD: saturated, no frame start. A frame-start rise moves it back to RUN.

Top module: `tdm_fsync_gen`

## Requirements
- R1: After reset every strobe is low and `bus_en_n_o` is high. Every assignment resets to the disabled value 6'b100000.
- R2: All state changes on the falling edge of `clk_i`. The first falling edge at which a frame-start input is sampled high, after being sampled low at the previous falling edge, starts slot 0. Every later group of 8 falling edges is one slot.
- R3: A strobe is high for exactly the 8 bit clocks of the slot whose number equals its assignment, starting at a slot start.
- R4: An assignment with bit 5 set keeps its strobe low.
- R5: An assignment at or beyond the number of slots between two frame starts never fires. With no frame start the slot count stops at 63 (HOLD) and does not wrap.
- R6: Write channel 0-3 selects `fs_tx_o[0..3]` and channel 4-7 selects `fs_rx_o[0..3]`. With `mode_shared_i`=0 the receive strobes follow `rx_sync_i`. With `mode_shared_i`=1 they follow `tx_sync_i` and `rx_sync_i` is ignored. The mode may change only while reset is asserted.
- R7: In separate mode, `bus_en_n_o` is low exactly while any transmit strobe is high. In shared mode it is low exactly while any strobe is high.
- R8: A write sampled at a falling edge becomes active at the first later falling edge that starts a slot on that channel's reference. While that reference counter is in IDLE or HOLD, the write becomes active at the very next falling edge. A slot in progress is neither cut short nor started late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; the design acts on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_shared_i | input | 1 | 0: receive strobes follow the receive frame start; 1: all strobes follow the transmit frame start |
| tx_sync_i | input | 1 | Transmit frame-start input |
| rx_sync_i | input | 1 | Receive frame-start input |
| wr_i | input | 1 | One-cycle assignment write strobe |
| wr_ch_i | input | 3 | Target strobe: 0-3 transmit, 4-7 receive |
| wr_slot_i | input | 6 | Slot number; bit 5 set disables the strobe |
| fs_tx_o | output | 4 | Transmit frame-sync strobes |
| fs_rx_o | output | 4 | Receive frame-sync strobes |
| bus_en_n_o | output | 1 | Active-low bus enable |

## Verification
The strobes and the bus enable are decoded from registers, so they change just after the falling edge that moves the counter. The bench samples them at the rising edge half a cycle later and compares them with a value computed from how many falling edges have passed since the frame start. A frame start driven before falling edge n opens slot 0 at edge n. A write driven before edge w is expected at the first slot start strictly after w. The bench computes that edge arithmetically from the frame length and offset, and checks both edges of the pulse around it.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    // Slot counter phases
    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_HOLD = 2'd2
    } cnt_state_e;

    localparam int unsigned SLOT_W_DEF = 6;
    localparam int unsigned BIT_W_DEF  = 3;
    localparam int unsigned NCH_DEF    = 4;
endpackage

// File: rtl/tsg_slot_counter.sv
module tsg_slot_counter
    import tsg_pkg::*;
#(
    parameter int unsigned SLOT_W = SLOT_W_DEF,
    parameter int unsigned BIT_W  = BIT_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sync_i,
    output logic              run_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              bound_o
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};
    localparam logic [BIT_W-1:0]  BIT_MAX  = {BIT_W{1'b1}};

    cnt_state_e        state_q, state_d;
    logic              sync_q;
    logic              rise;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;

    assign rise = sync_i & ~sync_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: if (rise) state_d = CNT_RUN;
            CNT_RUN: begin
                if (rise)
                    state_d = CNT_RUN;
                else if (bit_q == BIT_MAX && slot_q == SLOT_MAX)
                    state_d = CNT_HOLD;
            end
            CNT_HOLD: if (rise) state_d = CNT_RUN;
            default:  state_d = CNT_IDLE;
        endcase
    end

    // state register
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CNT_IDLE;
        else         state_q <= state_d;
    end

    // counting datapath
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= 1'b1;
            slot_q <= '0;
            bit_q  <= '0;
        end else begin
            sync_q <= sync_i;
            if (rise) begin
                slot_q <= '0;
                bit_q  <= '0;
            end else if (state_q == CNT_RUN) begin
                bit_q <= bit_q + 1'b1;
                if (bit_q == BIT_MAX && slot_q != SLOT_MAX)
                    slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign run_o   = (state_q == CNT_RUN);
    assign slot_o  = slot_q;
    assign bound_o = rise | (state_q != CNT_RUN) | (bit_q == BIT_MAX);

    // R2
    restart_zero_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        rise |=> (slot_q == '0 && bit_q == '0 && state_q == CNT_RUN));

    // R5
    sat_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (state_q == CNT_HOLD && !rise) |=> (slot_q == SLOT_MAX && state_q == CNT_HOLD));
endmodule

// File: rtl/tsg_assign_slot.sv
module tsg_assign_slot
    import tsg_pkg::*;
#(
    parameter int unsigned SLOT_W = SLOT_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic              bound_i,
    input  logic              run_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              fs_o
);
    localparam logic [SLOT_W-1:0] OFF_VAL = {1'b1, {(SLOT_W-1){1'b0}}};

    logic [SLOT_W-1:0] pend_q, act_q;
    logic              pend_v_q;

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q   <= OFF_VAL;
            pend_v_q <= 1'b0;
            act_q    <= OFF_VAL;
        end else begin
            if (pend_v_q && bound_i) begin
                act_q    <= pend_q;
                pend_v_q <= 1'b0;
            end
            if (wr_i) begin
                pend_q   <= wr_slot_i;
                pend_v_q <= 1'b1;
            end
        end
    end

    assign fs_o = run_i & ~act_q[SLOT_W-1] & (slot_i == act_q);

    // R4
    dis_quiet_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        act_q[SLOT_W-1] |-> !fs_o);

    // R8
    act_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !bound_i |=> $stable(act_q));
endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
    import tsg_pkg::*;
#(
    parameter int unsigned NUM_CH = NCH_DEF,
    parameter int unsigned SLOT_W = SLOT_W_DEF,
    parameter int unsigned BIT_W  = BIT_W_DEF
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          mode_shared_i,
    input  logic                          tx_sync_i,
    input  logic                          rx_sync_i,
    input  logic                          wr_i,
    input  logic [$clog2(2*NUM_CH)-1:0]   wr_ch_i,
    input  logic [SLOT_W-1:0]             wr_slot_i,
    output logic [NUM_CH-1:0]             fs_tx_o,
    output logic [NUM_CH-1:0]             fs_rx_o,
    output logic                          bus_en_n_o
);
    localparam int unsigned NOUT = 2 * NUM_CH;
    localparam int unsigned CH_W = $clog2(NOUT);

    logic              tx_run, rx_run, tx_bnd, rx_bnd;
    logic [SLOT_W-1:0] tx_slot, rx_slot;
    logic [NOUT-1:0]   fs_all, bnd_sel;

    tsg_slot_counter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) tx_cnt_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(tx_sync_i),
        .run_o(tx_run), .slot_o(tx_slot), .bound_o(tx_bnd)
    );

    tsg_slot_counter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) rx_cnt_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(rx_sync_i),
        .run_o(rx_run), .slot_o(rx_slot), .bound_o(rx_bnd)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        logic              use_tx;
        logic              run_s;
        logic [SLOT_W-1:0] slot_s;

        if (g < NUM_CH) begin : g_txref
            assign use_tx = 1'b1;
        end else begin : g_rxref
            assign use_tx = mode_shared_i;
        end

        assign run_s      = use_tx ? tx_run  : rx_run;
        assign slot_s     = use_tx ? tx_slot : rx_slot;
        assign bnd_sel[g] = use_tx ? tx_bnd  : rx_bnd;

        tsg_assign_slot #(.SLOT_W(SLOT_W)) slot_i (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .wr_i(wr_i && (wr_ch_i == CH_W'(g))),
            .wr_slot_i(wr_slot_i),
            .bound_i(bnd_sel[g]), .run_i(run_s), .slot_i(slot_s),
            .fs_o(fs_all[g])
        );

        // R3
        fs_start_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
            $rose(fs_all[g]) |-> $past(bnd_sel[g]));

        // R3
        fs_whole_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
            (fs_all[g] && !bnd_sel[g]) |=> fs_all[g]);
    end

    assign fs_tx_o    = fs_all[NUM_CH-1:0];
    assign fs_rx_o    = fs_all[NOUT-1:NUM_CH];
    assign bus_en_n_o = ~((|fs_tx_o) | (mode_shared_i & (|fs_rx_o)));

    // R7
    bus_quiet_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (fs_all == '0) |-> bus_en_n_o);
endmodule

// File: tb/tdm_fsync_gen_tb.sv
module tdm_fsync_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       tx_sync = 1'b0;
    logic       rx_sync = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] wr_ch = '0;
    logic [5:0] wr_slot = '0;
    logic [3:0] fs_tx, fs_rx;
    logic       bus_n;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    int asg [8];
    int g_ptx, g_prx, g_off, g_mw_edge, g_mw_ch, g_mw_val, g_eff;

    always #4 clk = ~clk;

    tdm_fsync_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_shared_i(mode),
        .tx_sync_i(tx_sync), .rx_sync_i(rx_sync),
        .wr_i(wr), .wr_ch_i(wr_ch), .wr_slot_i(wr_slot),
        .fs_tx_o(fs_tx), .fs_rx_o(fs_rx), .bus_en_n_o(bus_n)
    );

    function automatic bit uses_tx(int ch);
        return (ch < 4) || (mode == 1'b1);
    endfunction

    // position in frame (falling edges since slot 0 began); -1 if no frame yet
    function automatic int kref(int ch, int j);
        if (uses_tx(ch)) return j % g_ptx;
        if (j < g_off) return -1;
        return (j - g_off) % g_prx;
    endfunction

    task automatic check_edge(int j, string tag);
        logic [8:0] exp_v, got_v;
        logic [7:0] e;
        for (int ch = 0; ch < 8; ch++) begin
            int val, k, s;
            val = (g_mw_edge >= 0 && ch == g_mw_ch && j >= g_eff) ? g_mw_val : asg[ch];
            k = kref(ch, j);
            s = (k < 0) ? -1 : ((k / 8 > 63) ? 63 : k / 8);
            e[ch] = (k >= 0) && (val < 32) && (s == val);
        end
        exp_v = {e[7:4], e[3:0], ~((|e[3:0]) | (mode & (|e[7:4])))};
        got_v = {fs_rx, fs_tx, bus_n};
        ntests++;
        if (got_v !== exp_v) begin
            nfail++;
            $display("FAIL %s edge %0d: {rx,tx,bus_n} got %b expected %b", tag, j, got_v, exp_v);
        end
    endtask

    task automatic do_reset(logic shared);
        rst_n   <= 1'b0;
        mode    <= shared;
        tx_sync <= 1'b0;
        rx_sync <= 1'b0;
        wr      <= 1'b0;
        for (int i = 0; i < 8; i++) asg[i] = 32;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(posedge clk);
        // R1: reset state seen at the ports
        ntests++;
        if (fs_tx !== 4'h0 || fs_rx !== 4'h0 || bus_n !== 1'b1) begin
            nfail++;
            $display("FAIL R1 reset: tx %b rx %b bus_n %b expected 0000 0000 1", fs_tx, fs_rx, bus_n);
        end
    endtask

    // R6: channel 0-3 transmit, 4-7 receive
    task automatic write_slot(int ch, int val);
        @(posedge clk);
        wr <= 1'b1; wr_ch <= 3'(ch); wr_slot <= 6'(val);
        @(posedge clk);
        wr <= 1'b0;
        repeat (2) @(posedge clk);
        asg[ch] = val;
    endtask

    task automatic run(int ltx, int lrx, int off, int n, int mw_edge, int mw_ch, int mw_val, string tag);
        g_ptx = ltx * 8; g_prx = lrx * 8; g_off = off;
        g_mw_edge = mw_edge; g_mw_ch = mw_ch; g_mw_val = mw_val;
        g_eff = -1;
        if (mw_edge >= 0) begin
            for (int j = mw_edge + 1; j < mw_edge + 10; j++)
                if (g_eff < 0 && kref(mw_ch, j) >= 0 && kref(mw_ch, j) % 8 == 0) g_eff = j;
        end
        for (int i = 0; i <= n; i++) begin
            @(posedge clk);
            if (i > 0) check_edge(i - 1, tag);
            tx_sync <= (i % g_ptx == 0);
            rx_sync <= (i >= off) && ((i - off) % g_prx == 0);
            wr      <= (i == mw_edge);
            wr_ch   <= 3'(mw_ch);
            wr_slot <= 6'(mw_val);
        end
        tx_sync <= 1'b0; rx_sync <= 1'b0; wr <= 1'b0;
        if (mw_edge >= 0) asg[mw_ch] = mw_val;
    endtask

    initial begin
        // R1: no assignments, frames running, nothing may fire
        do_reset(1'b0);
        run(8, 8, 3, 140, -1, 0, 0, "R1");

        // R2/R3/R6/R7: separate mode, distinct lengths and offset
        do_reset(1'b0);
        write_slot(0, 0); write_slot(1, 3); write_slot(2, 7); write_slot(3, 9);
        write_slot(4, 1); write_slot(5, 0); write_slot(6, 5); write_slot(7, 9);
        run(10, 12, 21, 380, -1, 0, 0, "R2/R3/R6/R7 separate");

        // R6/R7: shared mode, receive sync toggling but ignored
        do_reset(1'b1);
        write_slot(0, 2); write_slot(1, 4); write_slot(4, 2); write_slot(5, 6);
        write_slot(6, 7); write_slot(7, 1);
        run(9, 5, 13, 300, -1, 0, 0, "R6/R7 shared");

        // R4: bit 5 set disables
        do_reset(1'b0);
        write_slot(0, 37); write_slot(1, 32); write_slot(2, 1); write_slot(4, 32);
        write_slot(5, 63); write_slot(6, 2);
        run(6, 6, 4, 160, -1, 0, 0, "R4");

        // R5: slots beyond the frame length
        do_reset(1'b0);
        write_slot(0, 31); write_slot(1, 5); write_slot(2, 3); write_slot(4, 4); write_slot(5, 0);
        run(4, 4, 7, 140, -1, 0, 0, "R5 frame length");

        // R5: single frame start, counter saturates at 63; receive never synced
        do_reset(1'b0);
        write_slot(0, 2); write_slot(1, 31); write_slot(2, 0); write_slot(4, 0);
        run(100, 100, 100000, 620, -1, 0, 0, "R5 saturation");

        // R8: disable written inside the active slot, pulse completes
        do_reset(1'b0);
        write_slot(0, 2); write_slot(5, 1);
        run(8, 8, 5, 220, 146, 0, 32, "R8 no truncation");

        // R8: move to a later slot written just before the old slot
        do_reset(1'b0);
        write_slot(0, 2); write_slot(5, 1);
        run(8, 8, 5, 220, 141, 0, 3, "R8 move tx");

        // R8: receive channel update follows the receive slot grid
        do_reset(1'b0);
        write_slot(0, 2); write_slot(5, 1);
        run(8, 8, 5, 220, 123, 5, 6, "R8 move rx");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            ntests++;
            nfail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule